// File: doc/BRIEF.md
# Effective Address Generator

This unit turns an addressing-mode selector, an instruction address field, a register read and the program counter into one result. The result is either an operand value or a 16-bit effective address, and a flag tells which one it is. A request is taken in one cycle. Most modes put the result on `result_o` in the next cycle, together with a one-cycle `valid_o` pulse.

The memory-indirect mode needs a pointer that lives in memory. The unit fetches it with a request/acknowledge read port, one byte at a time, low byte first. While it waits for the memory, `busy_o` is high and new requests are ignored.

Register-based modes read the register file through a combinational port (`rf_addr_o` / `rf_data_i`). One register index does not go to the register file: the index equal to `SP_IDX` (default 7) returns the stack-pointer input instead. This is the implicit stack source.

Top module: `ea_gen`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `busy_o` and `mem_req_o` are all low.
- R2: Mode code 0 (immediate) returns `field_i` on `result_o` as an operand, with `is_addr_o` = 0.
- R3: Mode code 1 (register) returns the selected register as an operand, with `is_addr_o` = 0. In every mode that reads a register, a `rsel_i` value of 7 selects `sp_i` and any other value selects `rf_data_i` for register `rsel_i`.
- R4: Mode code 2 (direct) returns `field_i` as an address, with `is_addr_o` = 1.
- R5: Mode code 4 (register-indirect) returns the selected register as an address, with `is_addr_o` = 1.
- R6: Mode code 5 (relative) returns `pc_i` plus `field_i[7:0]` read as a signed 8-bit value and sign-extended. The sum wraps modulo 2^16, and `field_i[15:8]` has no effect.
- R7: Mode code 6 (base) and mode code 7 (indexed) both return the selected register plus `field_i`, modulo 2^16, as an address.
- R8: Mode code 3 (memory-indirect) reads the byte at `field_i` and then the byte at `field_i`+1, where the second address wraps modulo 2^16. It returns {second byte, first byte} as an address.
- R9: `mem_req_o` and `mem_addr_o` stay unchanged until `mem_ack_i` is seen. `mem_req_o` is never raised for modes other than 3.
- R10: For modes other than 3, `valid_o` rises one cycle after the request is accepted and lasts one cycle if no new request follows. For mode 3, `valid_o` rises in the cycle after the second acknowledge.
- R11: While `busy_o` is high, `req_i` is ignored: it produces no result and no `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request; taken when `busy_o` is low |
| mode_i | input | 3 | Addressing-mode code |
| field_i | input | 16 | Address or data field from the instruction |
| rsel_i | input | 3 | Register index; 7 selects the stack pointer |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Stack pointer |
| rf_addr_o | output | 3 | Register file read index |
| rf_data_i | input | 16 | Register file read data, same cycle |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_ack_i | input | 1 | Memory read acknowledge, data valid |
| mem_data_i | input | 8 | Memory read byte |
| busy_o | output | 1 | Indirect fetch in progress |
| valid_o | output | 1 | Result strobe |
| is_addr_o | output | 1 | 1: result is an address; 0: operand |
| result_o | output | 16 | Operand or effective address |

## Verification
The assertions assume that `rf_data_i` settles in the same cycle as `rf_addr_o`. They also assume that `mem_data_i` is valid whenever `mem_ack_i` is high, and that the memory never acknowledges while no request is pending. The bench models the register file as a combinational function of the read index. Its memory responder only raises an acknowledge while `mem_req_o` is high, after a chosen number of wait cycles. The bench changes every input at the falling edge, so the design never sees an input change close to the edge it samples on.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [2:0] {
    M_IMM  = 3'd0,
    M_REG  = 3'd1,
    M_DIR  = 3'd2,
    M_MIND = 3'd3,
    M_RIND = 3'd4,
    M_REL  = 3'd5,
    M_BASE = 3'd6,
    M_IDX  = 3'd7
  } ea_mode_e;
endpackage

// File: rtl/ea_gen_srcsel.sv
module ea_gen_srcsel #(
  parameter int AW     = 16,
  parameter int RSW    = 3,
  parameter int SP_IDX = 7
) (
  input  logic [RSW-1:0] rsel_i,
  input  logic [AW-1:0]  rf_data_i,
  input  logic [AW-1:0]  sp_i,
  output logic [RSW-1:0] rf_addr_o,
  output logic [AW-1:0]  reg_val_o
);
  localparam logic [RSW-1:0] SP_SEL = RSW'(SP_IDX);

  assign rf_addr_o = rsel_i;
  assign reg_val_o = (rsel_i == SP_SEL) ? sp_i : rf_data_i;
endmodule

// File: rtl/ea_gen_calc.sv
module ea_gen_calc
  import ea_gen_pkg::*;
#(
  parameter int AW   = 16,
  parameter int OFFW = 8
) (
  input  ea_mode_e       mode_i,
  input  logic [AW-1:0]  field_i,
  input  logic [AW-1:0]  reg_val_i,
  input  logic [AW-1:0]  pc_i,
  output logic [AW-1:0]  val_o,
  output logic           is_addr_o
);
  localparam int EXTW = AW - OFFW;

  logic [AW-1:0] rel_off;
  logic [AW-1:0] add_a, add_b, sum;

  assign rel_off = {{EXTW{field_i[OFFW-1]}}, field_i[OFFW-1:0]};

  // one shared adder for all displacement modes
  always_comb begin
    if (mode_i == M_REL) begin
      add_a = pc_i;
      add_b = rel_off;
    end else begin
      add_a = reg_val_i;
      add_b = field_i;
    end
  end
  assign sum = add_a + add_b;

  always_comb begin
    val_o     = field_i;
    is_addr_o = 1'b1;
    unique case (mode_i)
      M_IMM:  begin val_o = field_i;   is_addr_o = 1'b0; end
      M_REG:  begin val_o = reg_val_i; is_addr_o = 1'b0; end
      M_DIR:  val_o = field_i;
      M_MIND: val_o = field_i;
      M_RIND: val_o = reg_val_i;
      M_REL, M_BASE, M_IDX: val_o = sum;
      default: val_o = field_i;
    endcase
  end
endmodule

// File: rtl/ea_gen_ind_fetch.sv
module ea_gen_ind_fetch #(
  parameter int AW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic            mem_ack_i,
  input  logic [AW/2-1:0] mem_data_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [AW-1:0]   word_o
);
  localparam int BW = AW / 2;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_e;

  st_e           st_q;
  logic [AW-1:0] base_q;
  logic [BW-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      base_q <= '0;
      lo_q   <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q   <= S_LO;
          base_q <= base_i;
        end
        S_LO: if (mem_ack_i) begin
          st_q <= S_HI;
          lo_q <= mem_data_i;
        end
        S_HI: if (mem_ack_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q != S_IDLE);
  assign busy_o     = (st_q != S_IDLE);
  assign mem_addr_o = (st_q == S_HI) ? base_q + AW'(1) : base_q;
  assign done_o     = (st_q == S_HI) && mem_ack_i;
  assign word_o     = {mem_data_i, lo_q};

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_hi_follows_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LO && mem_ack_i) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + AW'(1)));

  assert_done_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !mem_req_o);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RSW    = 3,
  parameter int OFFW   = 8,
  parameter int SP_IDX = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [2:0]      mode_i,
  input  logic [AW-1:0]   field_i,
  input  logic [RSW-1:0]  rsel_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [AW-1:0]   sp_i,
  output logic [RSW-1:0]  rf_addr_o,
  input  logic [AW-1:0]   rf_data_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_ack_i,
  input  logic [AW/2-1:0] mem_data_i,
  output logic            busy_o,
  output logic            valid_o,
  output logic            is_addr_o,
  output logic [AW-1:0]   result_o
);
  ea_mode_e      mode;
  logic [AW-1:0] reg_val, calc_val, ind_word;
  logic          calc_is_addr, accept, ind_start, ind_done;

  assign mode      = ea_mode_e'(mode_i);
  assign accept    = req_i && !busy_o;
  assign ind_start = accept && (mode == M_MIND);

  ea_gen_srcsel #(.AW(AW), .RSW(RSW), .SP_IDX(SP_IDX)) u_src (
    .rsel_i    (rsel_i),
    .rf_data_i (rf_data_i),
    .sp_i      (sp_i),
    .rf_addr_o (rf_addr_o),
    .reg_val_o (reg_val)
  );

  ea_gen_calc #(.AW(AW), .OFFW(OFFW)) u_calc (
    .mode_i    (mode),
    .field_i   (field_i),
    .reg_val_i (reg_val),
    .pc_i      (pc_i),
    .val_o     (calc_val),
    .is_addr_o (calc_is_addr)
  );

  ea_gen_ind_fetch #(.AW(AW)) u_ind (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (ind_start),
    .base_i     (field_i),
    .mem_ack_i  (mem_ack_i),
    .mem_data_i (mem_data_i),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o),
    .done_o     (ind_done),
    .word_o     (ind_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      is_addr_o <= 1'b0;
      result_o  <= '0;
    end else if (ind_done) begin
      valid_o   <= 1'b1;
      is_addr_o <= 1'b1;
      result_o  <= ind_word;
    end else if (accept && mode != M_MIND) begin
      valid_o   <= 1'b1;
      is_addr_o <= calc_is_addr;
      result_o  <= calc_val;
    end else begin
      valid_o   <= 1'b0;
    end
  end

  assert_direct_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && mode_i != M_MIND) |=> valid_o);

  assert_no_mem_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && mode_i != M_MIND) |=> !mem_req_o);

  assert_busy_ignores_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_ack_i) |=> !valid_o);

  assert_valid_not_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !mem_req_o);
endmodule

// File: tb/ea_gen_tb_top.sv
`timescale 1ns/1ps
module ea_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] field = '0;
  logic [2:0]  rsel = '0;
  logic [15:0] pc = '0;
  logic [15:0] sp = 16'hFF00;
  logic [2:0]  rf_addr;
  logic [15:0] rf_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_data = '0;
  logic        busy, valid, is_addr;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  int ack_lat = 0;
  int wait_cnt = 0;
  int log_n = 0;
  int hold_err = 0;
  logic [15:0] log_a [4];
  logic [15:0] hold_addr = '0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] rf_val(input logic [2:0] i);
    return {1'b0, i, 12'h020};
  endfunction

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign rf_data = rf_val(rf_addr);

  ea_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode), .field_i(field),
    .rsel_i(rsel), .pc_i(pc), .sp_i(sp), .rf_addr_o(rf_addr), .rf_data_i(rf_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_data_i(mem_data), .busy_o(busy), .valid_o(valid), .is_addr_o(is_addr),
    .result_o(result)
  );

  // memory responder: acknowledges after ack_lat wait cycles
  always @(negedge clk) begin
    if (mem_req) begin
      if (wait_cnt != 0 && mem_addr != hold_addr) hold_err++;
      hold_addr = mem_addr;
      if (wait_cnt == ack_lat) begin
        mem_ack  = 1'b1;
        mem_data = mem_byte(mem_addr);
        if (log_n < 4) log_a[log_n] = mem_addr;
        log_n++;
        wait_cnt = 0;
      end else begin
        mem_ack = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {mode, rsel, field, pc, expected, is_addr}
  localparam int NV = 13;
  localparam logic [54:0] VEC [NV] = '{
    {3'd0, 3'd0, 16'hBEEF, 16'h0000, 16'hBEEF, 1'b0}, // R2
    {3'd1, 3'd2, 16'h0000, 16'h0000, 16'h2020, 1'b0}, // R3
    {3'd1, 3'd7, 16'h0000, 16'h0000, 16'hFF00, 1'b0}, // R3 stack
    {3'd2, 3'd0, 16'h1234, 16'h0000, 16'h1234, 1'b1}, // R4
    {3'd4, 3'd5, 16'h0000, 16'h0000, 16'h5020, 1'b1}, // R5
    {3'd4, 3'd7, 16'h0000, 16'h0000, 16'hFF00, 1'b1}, // R5 stack
    {3'd5, 3'd0, 16'h0010, 16'h4000, 16'h4010, 1'b1}, // R6
    {3'd5, 3'd0, 16'hAAF0, 16'h4000, 16'h3FF0, 1'b1}, // R6 negative, upper ignored
    {3'd5, 3'd0, 16'h007F, 16'hFFF0, 16'h006F, 1'b1}, // R6 wrap
    {3'd5, 3'd0, 16'h0080, 16'h0010, 16'hFF90, 1'b1}, // R6 most negative
    {3'd6, 3'd3, 16'h0100, 16'h0000, 16'h3120, 1'b1}, // R7 base
    {3'd7, 3'd1, 16'hF000, 16'h0000, 16'h0020, 1'b1}, // R7 indexed wrap
    {3'd6, 3'd7, 16'h0200, 16'h0000, 16'h0100, 1'b1}  // R7 stack base
  };

  task automatic run_mind(input logic [15:0] f, input int lat);
    int k;
    logic [15:0] exp_w;
    ack_lat = lat;
    log_n = 0;
    hold_err = 0;
    exp_w = {mem_byte(f + 16'd1), mem_byte(f)};
    @(negedge clk);
    req = 1'b1; mode = 3'd3; field = f;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      // R11: conflicting request held while busy
      if (busy) begin req = 1'b1; mode = 3'd0; field = 16'h1111; end
      else req = 1'b0;
    end while (!valid && k < 60);
    req = 1'b0;
    chk(valid === 1'b1, "R10 indirect valid", {31'd0, valid}, 32'd1);
    chk(k == 1 + 2 * (lat + 1), "R10 indirect latency", k, 1 + 2 * (lat + 1));
    chk(result === exp_w, "R8 indirect word", result, exp_w);
    chk(is_addr === 1'b1, "R8 is_addr", {31'd0, is_addr}, 32'd1);
    chk(log_n == 2, "R8 read count", log_n, 2);
    chk(log_a[0] === f, "R8 first addr", log_a[0], f);
    chk(log_a[1] === f + 16'd1, "R8 second addr", log_a[1], f + 16'd1);
    chk(hold_err == 0, "R9 addr hold", hold_err, 0);
    @(negedge clk);
    chk(valid === 1'b0, "R11 no extra valid", {31'd0, valid}, 32'd0);
    chk(result === exp_w, "R11 result kept", result, exp_w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(valid === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "R1 reset",
        {29'd0, valid, busy, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] e;
      logic        ea;
      mode = VEC[i][54:52]; rsel = VEC[i][51:49]; field = VEC[i][48:33];
      pc = VEC[i][32:17]; e = VEC[i][16:1]; ea = VEC[i][0];
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(valid === 1'b1, "R10 valid", {31'd0, valid}, 32'd1);
      chk(result === e, "R2-7 vector result", result, e);
      chk(is_addr === ea, "R2-7 vector kind", {31'd0, is_addr}, {31'd0, ea});
      chk(mem_req === 1'b0, "R9 no mem req", {31'd0, mem_req}, 32'd0);
      @(negedge clk);
      chk(valid === 1'b0, "R10 single pulse", {31'd0, valid}, 32'd0);
    end

    // back-to-back direct requests: one result per cycle (R10)
    req = 1'b1; mode = 3'd2; field = 16'hA001;
    @(negedge clk);
    field = 16'hA002;
    chk(valid === 1'b1 && result === 16'hA001, "R4 back-to-back first", result, 16'hA001);
    @(negedge clk);
    req = 1'b0;
    chk(valid === 1'b1 && result === 16'hA002, "R4 back-to-back second", result, 16'hA002);

    run_mind(16'h2040, 0);
    run_mind(16'h30FF, 2);
    run_mind(16'hFFFF, 1); // R8 wrap of second address

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule